// File: doc/BRIEF.md
# Serial Ones-Count Accumulator

The block totals the set bits found in a series of data words that arrive one at a time. A word is offered on `word_in` together with a one-cycle `word_valid` strobe while `ready` is high; the block captures it into a shift register. It then scans the word one bit per cycle, shifting right and adding one to the running total whenever the low bit is set. The scan of a word stops as soon as the remaining shifted value is zero, so short words cost few cycles.

When the producer has no more words it pulses `series_end`. The block then raises `result_valid`, and `ones_count` shows the final total. Both hold until the next accepted word, which clears the total and starts a fresh series. A small controller sequences the shift register and the counter from two status bits: the low bit of the remaining value and a remaining-is-zero flag.

Top module: `popcnt_accum`

## Requirements
- R1: An asynchronous active-low reset returns the block at once to the idle state, with `ready` = 1, `result_valid` = 0 and `ones_count` = 0, even in the middle of a scan.
- R2: When `ready` = 1, `word_valid` = 1 and `series_end` = 0 at a clock edge, the word is captured; at the next edge `ready` is 0. If the block was idle (after reset or after a finished series), the total is cleared and `result_valid` drops to 0 in the same step.
- R3: `ones_count` is the number of set bits across all words of the series, reported when `result_valid` rises.
- R4: A word whose highest set bit is at position h keeps `ready` low for h + 2 cycles after its capture edge; an all-zero word keeps it low for exactly 1 cycle.
- R5: `ready` is high only while the block waits for input; a `word_valid` strobe while `ready` is low is ignored and does not change the total.
- R6: A `series_end` pulse while waiting for the next word of a series sets `result_valid` to 1 at the next edge, with the final total on `ones_count`.
- R7: If `word_valid` and `series_end` are both high while waiting, the end takes priority: the offered word is not counted and `result_valid` rises.
- R8: `result_valid` and `ones_count` hold their values until the next accepted word; a `series_end` pulse while idle is ignored.
- R9: The total wraps modulo 2^CNT_W (256 with default parameters).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | Strobe: a new word is on `word_in` |
| series_end | input | 1 | Strobe: no more words, present the total |
| word_in | input | WORD_W (8) | Data word to be counted |
| ready | output | 1 | Block can take a word or an end strobe |
| result_valid | output | 1 | `ones_count` is final |
| ones_count | output | CNT_W (8) | Running / final count of set bits |

## Verification
A controller stuck in a scan state shows at the ports as `ready` staying low past the h + 2 cycle window of the word just given, which the bench measures per word. A wrong shift or a lost increment shows only at the end of a series, as a mismatch between `ones_count` and the bench's own total when `result_valid` rises, so each series is kept short and varied. A step of the counter by anything other than zero or one during a scan, or `result_valid` rising without an end strobe, is caught on the very next cycle.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_INC   = 3'd2,
        ST_SHIFT = 3'd3,
        ST_NEXT  = 3'd4,
        ST_WAIT  = 3'd5
    } pc_state_e;

    typedef struct packed {
        pc_state_e state;
        logic      done;
    } pc_ctrl_s;

endpackage

// File: rtl/popcnt_ctrl.sv
module popcnt_ctrl
    import popcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_stb_i,
    input  logic end_stb_i,
    input  logic cur_lsb_i,
    input  logic cur_zero_i,
    input  logic nxt_lsb_i,
    input  logic nxt_zero_i,
    output logic load_o,
    output logic clear_o,
    output logic inc_o,
    output logic shift_o,
    output logic ready_o,
    output logic done_o
);

    pc_ctrl_s cs_q;
    pc_ctrl_s cs_d;

    // next state and completion flag
    always_comb begin
        cs_d = cs_q;
        case (cs_q.state)
            ST_IDLE: begin
                if (word_stb_i && !end_stb_i) begin
                    cs_d.state = ST_START;
                    cs_d.done  = 1'b0;
                end
            end
            ST_START, ST_NEXT: begin
                if (cur_zero_i)      cs_d.state = ST_WAIT;
                else if (cur_lsb_i)  cs_d.state = ST_INC;
                else                 cs_d.state = ST_SHIFT;
            end
            ST_INC, ST_SHIFT: begin
                if (nxt_zero_i)      cs_d.state = ST_WAIT;
                else if (nxt_lsb_i)  cs_d.state = ST_INC;
                else                 cs_d.state = ST_SHIFT;
            end
            ST_WAIT: begin
                if (end_stb_i) begin
                    cs_d.state = ST_IDLE;
                    cs_d.done  = 1'b1;
                end else if (word_stb_i) begin
                    cs_d.state = ST_NEXT;
                end
            end
            default: begin
                cs_d.state = ST_IDLE;
                cs_d.done  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.state <= ST_IDLE;
            cs_q.done  <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

    // datapath controls
    always_comb begin
        ready_o = (cs_q.state == ST_IDLE) || (cs_q.state == ST_WAIT);
        load_o  = ready_o && word_stb_i && !end_stb_i;
        clear_o = load_o && (cs_q.state == ST_IDLE);
        inc_o   = (cs_q.state == ST_INC);
        shift_o = (cs_q.state == ST_INC) || (cs_q.state == ST_SHIFT);
        done_o  = cs_q.done;
    end

endmodule

// File: rtl/popcnt_dp.sv
module popcnt_dp #(
    parameter int WORD_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              clear_i,
    input  logic              inc_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              cur_lsb_o,
    output logic              cur_zero_o,
    output logic              nxt_lsb_o,
    output logic              nxt_zero_o,
    output logic [CNT_W-1:0]  count_o
);

    typedef struct packed {
        logic [WORD_W-1:0] sreg;
        logic [CNT_W-1:0]  cnt;
    } dp_s;

    dp_s               dp_q;
    dp_s               dp_d;
    logic [WORD_W-1:0] shifted;

    assign shifted = dp_q.sreg >> 1;

    always_comb begin
        dp_d = dp_q;
        if (load_i) begin
            dp_d.sreg = word_i;
        end else if (shift_i) begin
            dp_d.sreg = shifted;
        end
        if (clear_i) begin
            dp_d.cnt = '0;
        end else if (inc_i) begin
            dp_d.cnt = dp_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q.sreg <= '0;
            dp_q.cnt  <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    // status towards the controller: current value and value after one shift
    assign cur_lsb_o  = dp_q.sreg[0];
    assign cur_zero_o = (dp_q.sreg == '0);
    assign nxt_lsb_o  = shifted[0];
    assign nxt_zero_o = (shifted == '0);
    assign count_o    = dp_q.cnt;

endmodule

// File: rtl/popcnt_accum.sv
module popcnt_accum #(
    parameter int WORD_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic              series_end,
    input  logic [WORD_W-1:0] word_in,
    output logic              ready,
    output logic              result_valid,
    output logic [CNT_W-1:0]  ones_count
);

    logic load, clear, inc, shift;
    logic cur_lsb, cur_zero, nxt_lsb, nxt_zero;

    popcnt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_stb_i (word_valid),
        .end_stb_i  (series_end),
        .cur_lsb_i  (cur_lsb),
        .cur_zero_i (cur_zero),
        .nxt_lsb_i  (nxt_lsb),
        .nxt_zero_i (nxt_zero),
        .load_o     (load),
        .clear_o    (clear),
        .inc_o      (inc),
        .shift_o    (shift),
        .ready_o    (ready),
        .done_o     (result_valid)
    );

    popcnt_dp #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .clear_i    (clear),
        .inc_i      (inc),
        .shift_i    (shift),
        .word_i     (word_in),
        .cur_lsb_o  (cur_lsb),
        .cur_zero_o (cur_zero),
        .nxt_lsb_o  (nxt_lsb),
        .nxt_zero_o (nxt_zero),
        .count_o    (ones_count)
    );

endmodule

// File: rtl/popcnt_accum_chk.sv
module popcnt_accum_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_valid,
    input logic             series_end,
    input logic             ready,
    input logic             result_valid,
    input logic [CNT_W-1:0] ones_count
);

    assert_valid_only_when_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ready);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (ones_count == $past(ones_count) || ones_count == $past(ones_count) + 1'b1));

    assert_valid_needs_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $past(series_end));

    assert_accept_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && word_valid && !series_end) |=> (!ready && !result_valid));

    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !word_valid && !series_end) |=> (ready && $stable(ones_count) && $stable(result_valid)));

    assert_end_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && word_valid && series_end) |=> (ready && $stable(ones_count)));

endmodule

bind popcnt_accum popcnt_accum_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid   (word_valid),
    .series_end   (series_end),
    .ready        (ready),
    .result_valid (result_valid),
    .ones_count   (ones_count)
);

// File: tb/popcnt_accum_tb.sv
module popcnt_accum_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_valid = 1'b0;
    logic       series_end = 1'b0;
    logic [7:0] word_in = '0;
    logic       ready;
    logic       result_valid;
    logic [7:0] ones_count;

    int n_chk = 0;
    int n_err = 0;
    int acc = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    popcnt_accum u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_valid   (word_valid),
        .series_end   (series_end),
        .word_in      (word_in),
        .ready        (ready),
        .result_valid (result_valid),
        .ones_count   (ones_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int ones(input logic [7:0] w);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic int busy_len(input logic [7:0] w);
        int h = -1;
        for (int i = 0; i < 8; i++) if (w[i]) h = i;
        return (h < 0) ? 1 : h + 2;
    endfunction

    // monitor: pops an expected total on each rising result_valid
    bit valid_prev = 1'b0;
    always @(negedge clk) begin
        if (result_valid && !valid_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected result", int'(ones_count), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(ones_count) == e, "R3/R9 series total", int'(ones_count), e);
            end
        end
        valid_prev = result_valid;
    end

    // driver: one word, optional strobe while busy (R5), checks busy length (R4)
    task automatic send_word(input logic [7:0] w, input bit poke, input bit fresh);
        int n;
        while (!ready) @(negedge clk);
        word_in    = w;
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        if (fresh) begin
            check(!result_valid, "R2 valid cleared on new series", int'(result_valid), 0);
            check(ones_count == 8'd0, "R2 total cleared on new series", int'(ones_count), 0);
        end
        check(!ready, "R2 busy after capture", int'(ready), 0);
        if (poke) begin
            word_in    = 8'hFF;
            word_valid = 1'b1;
        end
        n = 0;
        while (!ready) begin
            @(negedge clk);
            n++;
            word_valid = 1'b0;
        end
        check(n == busy_len(w), "R4 scan length", n, busy_len(w));
        acc += ones(w);
    endtask

    task automatic end_series(input bit with_word);
        while (!ready) @(negedge clk);
        exp_q.push_back(acc % 256);
        series_end = 1'b1;
        if (with_word) begin
            word_in    = 8'hFF;
            word_valid = 1'b1;
        end
        @(negedge clk);
        series_end = 1'b0;
        word_valid = 1'b0;
        check(result_valid, "R6 valid after end", int'(result_valid), 1);
        if (with_word) check(ready, "R7 end wins, no scan", int'(ready), 1);
        acc = 0;
    endtask

    initial begin
        logic [7:0] held;
        #2;
        check(ready && !result_valid && ones_count == 8'd0, "R1 reset state",
              int'(ones_count), 0);
        #10 rst_n = 1'b1;
        @(negedge clk);

        // R8: end while idle after reset is ignored
        series_end = 1'b1;
        @(negedge clk);
        series_end = 1'b0;
        @(negedge clk);
        check(!result_valid, "R8 end ignored when idle", int'(result_valid), 0);

        // series 1: mixed words, one strobe during a scan (R5)
        send_word(8'hB5, 1'b0, 1'b1);
        send_word(8'h3C, 1'b1, 1'b0);
        send_word(8'h00, 1'b0, 1'b0);
        send_word(8'h01, 1'b0, 1'b0);
        send_word(8'h80, 1'b1, 1'b0);
        end_series(1'b0);

        // R8: hold and ignore a further end strobe
        held = ones_count;
        repeat (5) @(negedge clk);
        check(result_valid && ones_count == held, "R8 result held", int'(ones_count), int'(held));
        series_end = 1'b1;
        @(negedge clk);
        series_end = 1'b0;
        @(negedge clk);
        check(result_valid && ones_count == held, "R8 end ignored after done",
              int'(ones_count), int'(held));

        // series 2: end together with a word (R7)
        send_word(8'hFF, 1'b0, 1'b1);
        send_word(8'h0F, 1'b0, 1'b0);
        end_series(1'b1);

        // series 3: wrap of the total (R9), 320 set bits -> 64
        for (int i = 0; i < 40; i++) send_word(8'hFF, 1'b0, i == 0);
        end_series(1'b0);

        // series 4: zero words only
        send_word(8'h00, 1'b0, 1'b1);
        send_word(8'h00, 1'b0, 1'b0);
        end_series(1'b0);

        // series 5: sparse bits
        send_word(8'h42, 1'b0, 1'b1);
        send_word(8'h81, 1'b1, 1'b0);
        end_series(1'b0);

        // R1: reset in the middle of a scan
        while (!ready) @(negedge clk);
        word_in    = 8'hF0;
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(ready && !result_valid && ones_count == 8'd0, "R1 reset during scan",
              int'(ones_count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule